// File: doc/BRIEF.md
# Coefficient Bank Switching Controller

This controller sits between a register write port and the coefficient storage of an audio processing path. Each write either lands in the live coefficient store, which the processing path uses, or in one of three shadow banks. A set of rate-dependent coefficients can be loaded into every shadow bank ahead of time. In automatic mode the controller then copies the matching bank into the live store whenever the detected sample rate changes, so no host has to take part.

The controller steers only a fixed group of bankable addresses. Every other address always goes straight to the live store. A gang option duplicates writes from the left-channel part of two address groups onto the matching right-channel part, using a separate mirror write lane. The bank copy runs as a sequencer that moves one word per cycle. It reads the shadow bank through a read port with combinational data and writes the word to the live store on the mirror lane one cycle later. A busy flag covers the read phase of the copy.

Top module: `coef_bank_ctrl`

## Requirements
- R1: While the synchronous active-high reset is applied, and in the first cycle after it, every write enable (live, live mirror, shadow, shadow mirror) is 0 and busy is 0.
- R2: A host write to an address that is not bankable appears on the live primary lane, with its address and data, in the cycle after it is presented. This holds in every mode value and also while a copy is running.
- R3: With mode 000, a write to a bankable address goes to the live primary lane one cycle later and produces no shadow write.
- R4: With mode 001, 010 or 011, a write to a bankable address produces shadow_we equal to 001, 010 or 100 respectively (shadow bank 1, 2 or 3), with the same address and data, and produces no live write.
- R5: With mode 101, 110 or 111, a write to a bankable address is dropped: no live or shadow write follows.
- R6: The bankable addresses are 0x29–0x36, 0x3A–0x3F and 0x58–0x5F, a total of 28 words.
- R7: When gang_en is 1, a write that is routed to a bankable address in 0x29–0x2F is repeated on the matching mirror lane (live or shadow) at address+7, and one in 0x58–0x5B at address+4, in the same cycle and with the same data. No other address is mirrored, and nothing is mirrored when gang_en is 0.
- R8: The bank copied for a rate code is: code 000 → bank_rd_sel 0 (bank 1), 011 → 1 (bank 2), and every other code → 2 (bank 3).
- R9: A copy starts when the mode changes to 100 from any other value, and when rate_chg pulses while the mode is 100. busy rises in the next cycle. A rate_chg pulse in any other mode has no effect.
- R10: A copy holds busy for exactly 28 cycles. In cycle k it reads bankable word k, in ascending address order, and in cycle k+1 it writes that word to the live mirror lane at the same address.
- R11: A host write to a bankable address that is presented while busy is 1 is dropped.
- R12: A rate_chg pulse in mode 100 during a copy restarts the copy from the first word, using the bank for the new rate, and busy then stays high for 28 further cycles.
- R13: In mode 100 with no copy running, a write to a bankable address goes straight to the live primary lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 8 | Host write address |
| host_data | input | DW | Host write data |
| bank_mode | input | 3 | Bank mode field |
| rate_code | input | 3 | Detected sample-rate code |
| rate_chg | input | 1 | Pulse: detected rate changed |
| gang_en | input | 1 | Left-to-right write duplication enable |
| live_we | output | 1 | Live store primary write enable |
| live_addr | output | 8 | Live store primary address |
| live_data | output | DW | Live store primary data |
| live_mir_we | output | 1 | Live store mirror/copy lane enable |
| live_mir_addr | output | 8 | Live store mirror/copy lane address |
| live_mir_data | output | DW | Live store mirror/copy lane data |
| shadow_we | output | 3 | One-hot shadow bank write enable |
| shadow_addr | output | 8 | Shadow primary address |
| shadow_data | output | DW | Shadow data, used by both shadow lanes |
| shadow_mir_we | output | 1 | Shadow mirror lane enable, for the bank named by shadow_we |
| shadow_mir_addr | output | 8 | Shadow mirror lane address |
| bank_rd_sel | output | 2 | Shadow bank being read by the copy |
| bank_rd_addr | output | 8 | Shadow address being read by the copy |
| bank_rd_data | input | DW | Combinational read data from the shadow banks |
| busy | output | 1 | Copy in progress |

## Verification
Two functions can act in the same cycle: a word written by the copy sequencer on the live mirror lane, and a non-bankable host write on the primary lane. The bench provokes this by issuing a non-bankable write part way through a copy. It then checks that both lanes carry their own address and data in the same cycle. In the same run, a bankable write during the copy must leave every write enable other than the copy lane low. A rate change in the middle of the copy must restart the sequence from the first word, reading the new bank, and the bench checks every word written after the restart.

// File: rtl/coef_bank_pkg.sv
package coef_bank_pkg;

    localparam int CB_AW   = 8;
    localparam int N_BANKS = 3;

    localparam logic [2:0] BM_OFF  = 3'b000;
    localparam logic [2:0] BM_UPD1 = 3'b001;
    localparam logic [2:0] BM_UPD3 = 3'b011;
    localparam logic [2:0] BM_AUTO = 3'b100;

    typedef logic [CB_AW-1:0] caddr_t;

    localparam caddr_t SEG0_LO = 8'h29;
    localparam caddr_t SEG0_HI = 8'h36;
    localparam caddr_t SEG1_LO = 8'h3A;
    localparam caddr_t SEG1_HI = 8'h3F;
    localparam caddr_t SEG2_LO = 8'h58;
    localparam caddr_t SEG2_HI = 8'h5F;

    localparam int SEG0_N  = int'(SEG0_HI) - int'(SEG0_LO) + 1;
    localparam int SEG1_N  = int'(SEG1_HI) - int'(SEG1_LO) + 1;
    localparam int SEG2_N  = int'(SEG2_HI) - int'(SEG2_LO) + 1;
    localparam int N_WORDS = SEG0_N + SEG1_N + SEG2_N;
    localparam int IDX_W   = $clog2(N_WORDS);

    // gang halves: left half of segment 0 and segment 2 mirror onto right half
    localparam caddr_t GANG0_STEP = caddr_t'(SEG0_N / 2);
    localparam caddr_t GANG1_STEP = caddr_t'(SEG2_N / 2);
    localparam caddr_t GANG0_HI   = SEG0_LO + GANG0_STEP - 8'd1;
    localparam caddr_t GANG1_HI   = SEG2_LO + GANG1_STEP - 8'd1;

    typedef struct packed {
        logic   we;
        caddr_t addr;
    } wport_t;

    function automatic logic is_bankable(caddr_t a);
        return (a >= SEG0_LO && a <= SEG0_HI) ||
               (a >= SEG1_LO && a <= SEG1_HI) ||
               (a >= SEG2_LO && a <= SEG2_HI);
    endfunction

    function automatic logic is_gang_src(caddr_t a);
        return (a >= SEG0_LO && a <= GANG0_HI) ||
               (a >= SEG2_LO && a <= GANG1_HI);
    endfunction

    function automatic caddr_t gang_dst(caddr_t a);
        return (a <= GANG0_HI) ? a + GANG0_STEP : a + GANG1_STEP;
    endfunction

    function automatic caddr_t slot_addr(logic [IDX_W-1:0] i);
        int k;
        k = int'(i);
        if (k < SEG0_N)
            return SEG0_LO + caddr_t'(k);
        else if (k < SEG0_N + SEG1_N)
            return SEG1_LO + caddr_t'(k - SEG0_N);
        else
            return SEG2_LO + caddr_t'(k - SEG0_N - SEG1_N);
    endfunction

    function automatic logic [1:0] rate_to_bank(logic [2:0] r);
        case (r)
            3'b000:  return 2'd0;
            3'b011:  return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/coef_bank_steer.sv
module coef_bank_steer
    import coef_bank_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_we,
    input  caddr_t             host_addr,
    input  logic [DW-1:0]      host_data,
    input  logic [2:0]         mode,
    input  logic               gang_en,
    input  logic               busy,
    output wport_t             live_a,
    output logic [DW-1:0]      live_a_data,
    output wport_t             live_b,
    output logic [N_BANKS-1:0] sh_we,
    output caddr_t             sh_addr,
    output logic [DW-1:0]      sh_data,
    output wport_t             sh_mir
);

    logic               bank_hit, accept, direct, to_shadow, mirror;
    logic [N_BANKS-1:0] sh_sel;
    caddr_t             mir_addr;

    always_comb begin
        bank_hit  = is_bankable(host_addr);
        accept    = host_we && !(bank_hit && busy);
        direct    = !bank_hit || mode == BM_OFF || mode == BM_AUTO;
        to_shadow = bank_hit && mode >= BM_UPD1 && mode <= BM_UPD3;
        mirror    = bank_hit && gang_en && is_gang_src(host_addr);
        mir_addr  = gang_dst(host_addr);
    end

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank_sel
        assign sh_sel[b] = to_shadow && (mode == 3'(b + 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_a      <= '0;
            live_b      <= '0;
            live_a_data <= '0;
            sh_we       <= '0;
            sh_addr     <= '0;
            sh_data     <= '0;
            sh_mir      <= '0;
        end else begin
            live_a.we   <= accept && direct;
            live_a.addr <= host_addr;
            live_a_data <= host_data;
            live_b.we   <= accept && direct && mirror;
            live_b.addr <= mir_addr;
            sh_we       <= accept ? sh_sel : '0;
            sh_addr     <= host_addr;
            sh_data     <= host_data;
            sh_mir.we   <= accept && to_shadow && mirror;
            sh_mir.addr <= mir_addr;
        end
    end

    AST_SHADOW_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sh_we)); // R4

    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (rst)
        (host_we && busy && is_bankable(host_addr)) |=> !live_a.we && sh_we == '0 && !sh_mir.we); // R11

    AST_MIRROR_WITH_PRIMARY: assert property (@(posedge clk) disable iff (rst)
        (live_b.we || sh_mir.we) |-> (live_a.we || sh_we != '0)); // R7

endmodule

// File: rtl/coef_bank_copy.sv
module coef_bank_copy
    import coef_bank_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [1:0]    start_bank,
    input  logic [DW-1:0] rd_data,
    output logic          busy,
    output logic [1:0]    rd_sel,
    output caddr_t        rd_addr,
    output wport_t        wr,
    output logic [DW-1:0] wr_data
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

    logic [IDX_W-1:0] idx;
    logic [1:0]       bank_q;

    assign rd_sel  = bank_q;
    assign rd_addr = slot_addr(idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            idx     <= '0;
            bank_q  <= '0;
            wr      <= '0;
            wr_data <= '0;
        end else begin
            wr.we   <= busy;
            wr.addr <= rd_addr;
            wr_data <= rd_data;
            if (start) begin
                busy   <= 1'b1;
                idx    <= '0;
                bank_q <= start_bank;
            end else if (busy) begin
                if (idx == LAST_IDX) begin
                    busy <= 1'b0;
                    idx  <= '0;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    AST_COPY_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        wr.we |-> is_bankable(wr.addr)); // R10

    AST_COPY_ENDS_AT_TOP: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (wr.we && wr.addr == SEG2_HI)); // R10

endmodule

// File: rtl/coef_bank_ctrl.sv
module coef_bank_ctrl
    import coef_bank_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_we,
    input  logic [CB_AW-1:0]   host_addr,
    input  logic [DW-1:0]      host_data,
    input  logic [2:0]         bank_mode,
    input  logic [2:0]         rate_code,
    input  logic               rate_chg,
    input  logic               gang_en,
    output logic               live_we,
    output logic [CB_AW-1:0]   live_addr,
    output logic [DW-1:0]      live_data,
    output logic               live_mir_we,
    output logic [CB_AW-1:0]   live_mir_addr,
    output logic [DW-1:0]      live_mir_data,
    output logic [N_BANKS-1:0] shadow_we,
    output logic [CB_AW-1:0]   shadow_addr,
    output logic [DW-1:0]      shadow_data,
    output logic               shadow_mir_we,
    output logic [CB_AW-1:0]   shadow_mir_addr,
    output logic [1:0]         bank_rd_sel,
    output logic [CB_AW-1:0]   bank_rd_addr,
    input  logic [DW-1:0]      bank_rd_data,
    output logic               busy
);

    logic [2:0]    mode_q;
    logic          copy_start;
    wport_t        live_a, live_b, sh_mir, cp_wr;
    logic [DW-1:0] live_a_data, cp_data;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= BM_OFF;
        else     mode_q <= bank_mode;
    end

    assign copy_start = (bank_mode == BM_AUTO) && (rate_chg || mode_q != BM_AUTO);

    coef_bank_steer #(.DW(DW)) u_steer (
        .clk         (clk),
        .rst         (rst),
        .host_we     (host_we),
        .host_addr   (host_addr),
        .host_data   (host_data),
        .mode        (bank_mode),
        .gang_en     (gang_en),
        .busy        (busy),
        .live_a      (live_a),
        .live_a_data (live_a_data),
        .live_b      (live_b),
        .sh_we       (shadow_we),
        .sh_addr     (shadow_addr),
        .sh_data     (shadow_data),
        .sh_mir      (sh_mir)
    );

    coef_bank_copy #(.DW(DW)) u_copy (
        .clk        (clk),
        .rst        (rst),
        .start      (copy_start),
        .start_bank (rate_to_bank(rate_code)),
        .rd_data    (bank_rd_data),
        .busy       (busy),
        .rd_sel     (bank_rd_sel),
        .rd_addr    (bank_rd_addr),
        .wr         (cp_wr),
        .wr_data    (cp_data)
    );

    assign live_we         = live_a.we;
    assign live_addr       = live_a.addr;
    assign live_data       = live_a_data;
    assign live_mir_we     = cp_wr.we | live_b.we;
    assign live_mir_addr   = cp_wr.we ? cp_wr.addr : live_b.addr;
    assign live_mir_data   = cp_wr.we ? cp_data : live_a_data;
    assign shadow_mir_we   = sh_mir.we;
    assign shadow_mir_addr = sh_mir.addr;

    AST_LANE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(cp_wr.we && live_b.we)); // R10

    AST_RATE_STARTS_COPY: assert property (@(posedge clk) disable iff (rst)
        (bank_mode == BM_AUTO && rate_chg) |=> busy); // R9

    AST_NO_COPY_OUTSIDE_AUTO: assert property (@(posedge clk) disable iff (rst)
        (bank_mode != BM_AUTO && !busy) |=> !busy); // R9

    AST_NONBANK_PASS: assert property (@(posedge clk) disable iff (rst)
        (host_we && !is_bankable(host_addr)) |=> (live_we && live_addr == $past(host_addr))); // R2

endmodule

// File: tb/coef_bank_ctrl_test.sv
module coef_bank_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_data = '0;
    logic [2:0]  bank_mode = 3'b000;
    logic [2:0]  rate_code = 3'b011;
    logic        rate_chg = 1'b0;
    logic        gang_en = 1'b0;
    logic        live_we, live_mir_we, shadow_mir_we, busy;
    logic [7:0]  live_addr, live_mir_addr, shadow_addr, shadow_mir_addr, bank_rd_addr;
    logic [31:0] live_data, live_mir_data, shadow_data, bank_rd_data;
    logic [2:0]  shadow_we;
    logic [1:0]  bank_rd_sel;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    // shadow bank model: word content derived from bank and address
    assign bank_rd_data = {6'd0, bank_rd_sel, 8'h5A, 8'h00, bank_rd_addr};

    coef_bank_ctrl uut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr), .host_data(host_data),
        .bank_mode(bank_mode), .rate_code(rate_code), .rate_chg(rate_chg), .gang_en(gang_en),
        .live_we(live_we), .live_addr(live_addr), .live_data(live_data),
        .live_mir_we(live_mir_we), .live_mir_addr(live_mir_addr), .live_mir_data(live_mir_data),
        .shadow_we(shadow_we), .shadow_addr(shadow_addr), .shadow_data(shadow_data),
        .shadow_mir_we(shadow_mir_we), .shadow_mir_addr(shadow_mir_addr),
        .bank_rd_sel(bank_rd_sel), .bank_rd_addr(bank_rd_addr), .bank_rd_data(bank_rd_data),
        .busy(busy)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic [7:0] slot(int k);
        if (k < 14) return 8'(8'h29 + k);
        if (k < 20) return 8'(8'h3A + k - 14);
        return 8'(8'h58 + k - 20);
    endfunction

    function automatic bit bankable(logic [7:0] a);
        return (a >= 8'h29 && a <= 8'h36) || (a >= 8'h3A && a <= 8'h3F) || (a >= 8'h58 && a <= 8'h5F);
    endfunction

    function automatic logic [31:0] model(logic [1:0] b, logic [7:0] a);
        return {6'd0, b, 8'h5A, 8'h00, a};
    endfunction

    // called at the negedge where busy has just risen; walks the whole copy (R10)
    task automatic copy_watch(input logic [1:0] b, input string req);
        for (int k = 0; k < 28; k++) begin
            check(busy && bank_rd_sel == b && bank_rd_addr == slot(k), req,
                  {busy, bank_rd_sel, bank_rd_addr}, {1'b1, b, slot(k)});
            if (k > 0)
                check(live_mir_we && live_mir_addr == slot(k-1) && live_mir_data == model(b, slot(k-1)),
                      {req, " R10 copy write"}, {live_mir_we, live_mir_addr, live_mir_data},
                      {1'b1, slot(k-1), model(b, slot(k-1))});
            tick();
        end
        check(!busy && live_mir_we && live_mir_addr == 8'h5F && live_mir_data == model(b, 8'h5F),
              "R10 copy end", {busy, live_mir_we, live_mir_addr}, {1'b0, 1'b1, 8'h5F});
        tick();
        check(!live_mir_we, "R10 lane idle after copy", live_mir_we, 1'b0);
    endtask

    task automatic sweep_write(input logic [2:0] m, input bit g, input logic [7:0] a);
        logic [31:0] d;
        bit bk, mir, e_live, e_lmir, e_smir;
        logic [2:0] e_sh;
        logic [7:0] ma;
        bit ok;
        string req;
        d   = {8'hA5, a, 5'd0, m, 7'd0, g};
        bk  = bankable(a);
        mir = g && ((a >= 8'h29 && a <= 8'h2F) || (a >= 8'h58 && a <= 8'h5B));
        ma  = (a <= 8'h2F) ? a + 8'd7 : a + 8'd4;
        e_live = !bk || m == 3'd0 || m == 3'd4;
        e_lmir = bk && (m == 3'd0 || m == 3'd4) && mir;
        e_sh   = (bk && m >= 3'd1 && m <= 3'd3) ? 3'(1 << (m - 1)) : 3'b000;
        e_smir = (e_sh != 0) && mir;
        host_we = 1'b1; host_addr = a; host_data = d;
        tick();
        host_we = 1'b0;
        ok = live_we == e_live && live_mir_we == e_lmir && shadow_we == e_sh && shadow_mir_we == e_smir;
        if (e_live) ok = ok && live_addr == a && live_data == d;
        if (e_lmir) ok = ok && live_mir_addr == ma && live_mir_data == d;
        if (e_sh != 0) ok = ok && shadow_addr == a && shadow_data == d;
        if (e_smir) ok = ok && shadow_mir_addr == ma;
        if (!bk) req = "R2";
        else if (mir && (e_lmir || e_smir)) req = "R7/R6";
        else if (m == 3'd0) req = "R3/R6";
        else if (m == 3'd4) req = "R13/R6";
        else if (m <= 3'd3) req = "R4/R6";
        else req = "R5/R6";
        check(ok, req, {live_we, live_mir_we, shadow_we, shadow_mir_we, live_mir_addr, shadow_mir_addr},
              {e_live, e_lmir, e_sh, e_smir, e_lmir ? ma : live_mir_addr, e_smir ? ma : shadow_mir_addr});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [2:0] prev;
        // R1: reset state
        repeat (3) tick();
        check(!live_we && !live_mir_we && shadow_we == 0 && !shadow_mir_we && !busy, "R1 in reset",
              {live_we, live_mir_we, shadow_we, shadow_mir_we, busy}, 0);
        rst = 1'b0;
        tick();
        check(!live_we && !live_mir_we && shadow_we == 0 && !shadow_mir_we && !busy, "R1 after reset",
              {live_we, live_mir_we, shadow_we, shadow_mir_we, busy}, 0);

        // exhaustive address sweep for every mode, with and without ganging
        prev = 3'd0;
        for (int g = 0; g < 2; g++) begin
            for (int m = 0; m < 8; m++) begin
                bank_mode = 3'(m);
                gang_en   = 1'(g);
                tick();
                if (m == 4 && prev != 3'd4) copy_watch(2'd1, "R9 entry copy");
                prev = 3'(m);
                for (int a = 0; a < 256; a++) sweep_write(3'(m), 1'(g), 8'(a));
            end
        end

        // R8: rate-code to bank mapping in automatic mode
        bank_mode = 3'd4;
        tick();
        while (busy) tick();
        tick();
        for (int c = 0; c < 8; c++) begin
            logic [1:0] eb;
            eb = (c == 0) ? 2'd0 : (c == 3) ? 2'd1 : 2'd2;
            rate_code = 3'(c);
            rate_chg  = 1'b1;
            tick();
            rate_chg = 1'b0;
            check(busy && bank_rd_sel == eb, "R8 rate map", {busy, bank_rd_sel}, {1'b1, eb});
            while (busy) tick();
            tick();
        end

        // R9: rate change outside automatic mode does nothing
        bank_mode = 3'd0;
        tick();
        rate_chg = 1'b1;
        tick();
        rate_chg = 1'b0;
        tick();
        check(!busy, "R9 no copy outside auto", busy, 1'b0);

        // copy in progress: drop, concurrent non-bankable write, restart
        rate_code = 3'b000;
        bank_mode = 3'd4;
        gang_en   = 1'b1;
        tick();
        check(busy && bank_rd_sel == 2'd0, "R9 entry start", {busy, bank_rd_sel}, {1'b1, 2'd0});
        tick(); tick();
        host_we = 1'b1; host_addr = 8'h2A; host_data = 32'h1111_2222;
        tick();
        host_we = 1'b0;
        check(!live_we && shadow_we == 0 && !shadow_mir_we && live_mir_addr != 8'h31, "R11 bankable dropped while busy",
              {live_we, shadow_we, live_mir_addr}, {1'b0, 3'b000, 8'h00});
        host_we = 1'b1; host_addr = 8'h10; host_data = 32'h3333_4444;
        tick();
        host_we = 1'b0;
        check(live_we && live_addr == 8'h10 && live_data == 32'h3333_4444, "R2 beside copy lane",
              {live_we, live_addr, live_data}, {1'b1, 8'h10, 32'h3333_4444});
        check(live_mir_we && live_mir_addr == slot(3) && live_mir_data == model(2'd0, slot(3)), "R10 copy beside host write",
              {live_mir_we, live_mir_addr, live_mir_data}, {1'b1, slot(3), model(2'd0, slot(3))});
        rate_code = 3'b110;
        rate_chg  = 1'b1;
        tick();
        rate_chg = 1'b0;
        copy_watch(2'd2, "R12 restart");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule